// File: doc/BRIEF.md
# Ternary Stateful Gate Executor

This block is a clock-accurate digital model of a small bank of three-valued memory cells. Gates of three-valued Łukasiewicz logic are evaluated inside the bank, in the way a resistive crossbar evaluates them. Each cell holds a trit: 0 (false, high resistance), 1 (intermediate) or 2 (true, low resistance). A gate names two input cells and one output cell, and only the output cell is ever written.

Gates that compute a value work in place. First the output cell is cleared to 0. Then, on each operation clock, the cell may be raised toward a level that the latched input trits select, and it never goes down. Because of this, inversion needs two clocks and implication needs three, while strong disjunction finishes in one. The constant gates write their value directly. A caller pulses `start` with an opcode and three cell addresses, and then waits for the one-cycle `done` pulse. A combinational read port lets the caller look at any cell.

Top module: `trit_gate_engine`

## Requirements
- R1: After reset every cell holds 0, `busy`, `done` and `error` are low, and a cell never holds the code 3.
- R2: The constant opcodes write the output cell without looking at the inputs: opcode 0 writes 0, opcode 1 writes 2 and opcode 2 writes 1. `done` is high after the second rising edge counted from the edge that samples `start`.
- R3: A computing gate spends one clock clearing the output cell to 0. After that clock the output cell only rises.
- R4: Opcode 3 (inversion) writes 2 − A after two raise clocks, with `done` high after the fourth edge. The first raise clock sets level 1 when A ≤ 1. The second sets level 2 when A = 0.
- R5: Opcode 4 (implication) writes min(2, 2 − A + B) after three raise clocks, with `done` high after the fifth edge.
- R6: Opcode 5 (strong disjunction) writes min(2, A + B) after one raise clock, with `done` high after the third edge.
- R7: No cell other than the addressed output cell changes. The input trits are sampled before the clear clock, so the output address may equal an input address.
- R8: A `start` that arrives while `busy` is high is ignored. It changes no cell and does not alter the running gate.
- R9: Opcodes 6 and 7 leave every cell unchanged and raise `error` together with `done`, after the second edge.
- R10: `busy` is high from the edge that accepts `start` until `done`. `done` lasts exactly one cycle, during which `busy` is low, and `error` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gate (taken only while idle) |
| opcode | input | 3 | Gate selector: 0 zero, 1 one, 2 half, 3 inversion, 4 implication, 5 strong disjunction |
| addrA | input | AW | First input cell |
| addrB | input | AW | Second input cell |
| addrOut | input | AW | Output cell |
| rdAddr | input | AW | Read-port cell address |
| rdData | output | 2 | Trit held in cell `rdAddr` |
| busy | output | 1 | Gate in progress |
| done | output | 1 | One-cycle pulse: result is in the output cell |
| error | output | 1 | Undefined opcode, pulsed with `done` |

## Verification
The bench builds the block with its default of 8 cells, so AW is 3. This keeps a full scan of the bank after every gate cheap, and the scan proves that only the addressed cell moved. With only eight cells, random addresses often coincide. That exposes the cases where the output aliases an input, and where both inputs name the same cell. Every gate is run over its full truth table, starting from a pre-set nonzero output value so that the clear clock is exercised. A timed test sends a second `start` into a running implication.

// File: rtl/trit_pkg.sv
package trit_pkg;

  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_LO  = 2'd0;
  localparam trit_t TRIT_MID = 2'd1;
  localparam trit_t TRIT_HI  = 2'd2;

  localparam logic [2:0] OP_ZERO = 3'd0;
  localparam logic [2:0] OP_ONE  = 3'd1;
  localparam logic [2:0] OP_HALF = 3'd2;
  localparam logic [2:0] OP_INV  = 3'd3;
  localparam logic [2:0] OP_IMP  = 3'd4;
  localparam logic [2:0] OP_SDIS = 3'd5;

  localparam int STEP_W = 2;

  typedef enum logic [2:0] {
    RULE_NONE,
    RULE_SDIS,
    RULE_INV1,
    RULE_INV2,
    RULE_IMP1,
    RULE_IMP2,
    RULE_IMP3
  } rule_e;

  typedef struct packed {
    logic  capture;
    logic  clear;
    logic  writeConst;
    trit_t constVal;
    logic  raise;
    rule_e rule;
  } strobe_t;

endpackage

// File: rtl/trit_step_rule.sv
module trit_step_rule
  import trit_pkg::*;
(
  input  rule_e rule,
  input  trit_t a,
  input  trit_t b,
  output trit_t level
);
  logic [2:0] sumAB;
  logic [2:0] bPlus1;

  always_comb begin
    sumAB  = {1'b0, a} + {1'b0, b};
    bPlus1 = {1'b0, b} + 3'd1;
    level  = TRIT_LO;
    unique case (rule)
      RULE_SDIS: level = (sumAB >= 3'd2) ? TRIT_HI : sumAB[1:0];
      RULE_INV1: level = (a <= TRIT_MID) ? TRIT_MID : TRIT_LO;
      RULE_INV2: level = (a == TRIT_LO) ? TRIT_HI : TRIT_LO;
      RULE_IMP1: level = (a <= b) ? TRIT_MID : TRIT_LO;
      RULE_IMP2: level = (a <= b) ? TRIT_HI : TRIT_LO;
      RULE_IMP3: level = ({1'b0, a} == bPlus1) ? TRIT_MID : TRIT_LO;
      default:   level = TRIT_LO;
    endcase
  end
endmodule

// File: rtl/trit_cell_bank.sv
module trit_cell_bank
  import trit_pkg::*;
#(
  parameter  int CELLS = 8,
  localparam int AW    = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] selA,
  input  logic [AW-1:0] selB,
  input  logic [AW-1:0] selOut,
  input  logic [AW-1:0] rdAddr,
  output trit_t         rdData,
  output trit_t         outVal
);
  trit_t cellQ [CELLS];
  trit_t capA, capB;
  trit_t target;
  trit_t nextOut;
  logic  wrEn;

  trit_step_rule rule_i (
    .rule (stb.rule),
    .a    (capA),
    .b    (capB),
    .level(target)
  );

  always_comb begin
    nextOut = cellQ[selOut];
    if (stb.writeConst)
      nextOut = stb.constVal;
    else if (stb.clear)
      nextOut = TRIT_LO;
    else if (stb.raise && (target > cellQ[selOut]))
      nextOut = target;
  end

  assign wrEn = stb.writeConst | stb.clear | stb.raise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CELLS; i++) cellQ[i] <= TRIT_LO;
    end else if (wrEn) begin
      cellQ[selOut] <= nextOut;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capA <= TRIT_LO;
      capB <= TRIT_LO;
    end else if (stb.capture) begin
      capA <= cellQ[selA];
      capB <= cellQ[selB];
    end
  end

  assign rdData = cellQ[rdAddr];
  assign outVal = cellQ[selOut];
endmodule

// File: rtl/trit_gate_ctrl.sv
module trit_gate_ctrl
  import trit_pkg::*;
#(
  parameter  int CELLS = 8,
  localparam int AW    = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    opcode,
  input  logic [AW-1:0] addrA,
  input  logic [AW-1:0] addrB,
  input  logic [AW-1:0] addrOut,
  output logic [AW-1:0] selA,
  output logic [AW-1:0] selB,
  output logic [AW-1:0] selOut,
  output strobe_t       stb,
  output logic          busy,
  output logic          done,
  output logic          error
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_STEP} state_e;

  state_e            state;
  logic [2:0]        opR;
  logic [STEP_W-1:0] stepCnt;
  logic [STEP_W-1:0] lastStep;
  logic              isConst, isCompute;

  assign isConst   = (opR == OP_ZERO) || (opR == OP_ONE) || (opR == OP_HALF);
  assign isCompute = (opR == OP_INV) || (opR == OP_IMP) || (opR == OP_SDIS);

  always_comb begin
    unique case (opR)
      OP_INV:  lastStep = STEP_W'(1);
      OP_IMP:  lastStep = STEP_W'(2);
      default: lastStep = STEP_W'(0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opR     <= OP_ZERO;
      selA    <= '0;
      selB    <= '0;
      selOut  <= '0;
      stepCnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            opR    <= opcode;
            selA   <= addrA;
            selB   <= addrB;
            selOut <= addrOut;
            busy   <= 1'b1;
            state  <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          stepCnt <= '0;
          if (isCompute) begin
            state <= ST_STEP;
          end else begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
            error <= !isConst;
          end
        end
        ST_STEP: begin
          stepCnt <= stepCnt + STEP_W'(1);
          if (stepCnt == lastStep) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb      = '0;
    stb.rule = RULE_NONE;
    unique case (state)
      ST_FIRST: begin
        if (isConst) begin
          stb.writeConst = 1'b1;
          stb.constVal   = (opR == OP_ZERO) ? TRIT_LO :
                           (opR == OP_ONE)  ? TRIT_HI : TRIT_MID;
        end else if (isCompute) begin
          stb.capture = 1'b1;
          stb.clear   = 1'b1;
        end
      end
      ST_STEP: begin
        stb.raise = 1'b1;
        if (opR == OP_SDIS)
          stb.rule = RULE_SDIS;
        else if (opR == OP_INV)
          stb.rule = (stepCnt == '0) ? RULE_INV1 : RULE_INV2;
        else if (opR == OP_IMP)
          stb.rule = (stepCnt == '0) ? RULE_IMP1 :
                     (stepCnt == STEP_W'(1)) ? RULE_IMP2 : RULE_IMP3;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trit_gate_engine.sv
module trit_gate_engine
  import trit_pkg::*;
#(
  parameter  int CELLS = 8,
  localparam int AW    = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    opcode,
  input  logic [AW-1:0] addrA,
  input  logic [AW-1:0] addrB,
  input  logic [AW-1:0] addrOut,
  input  logic [AW-1:0] rdAddr,
  output logic [1:0]    rdData,
  output logic          busy,
  output logic          done,
  output logic          error
);
  strobe_t       stb;
  logic [AW-1:0] selA, selB, selOut;
  trit_t         outVal;

  trit_gate_ctrl #(.CELLS(CELLS)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .addrA(addrA), .addrB(addrB), .addrOut(addrOut),
    .selA(selA), .selB(selB), .selOut(selOut), .stb(stb),
    .busy(busy), .done(done), .error(error)
  );

  trit_cell_bank #(.CELLS(CELLS)) bank_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .selA(selA), .selB(selB), .selOut(selOut),
    .rdAddr(rdAddr), .rdData(rdData), .outVal(outVal)
  );
endmodule

// File: rtl/trit_gate_engine_chk.sv
module trit_gate_engine_chk
  import trit_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       error,
  input strobe_t    stb,
  input trit_t      outVal,
  input logic [1:0] rdData
);
  assert_trit_code_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdData != 2'd3);

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (outVal == TRIT_LO));

  assert_raise_monotone_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.raise |=> (outVal >= $past(outVal)));

  assert_error_with_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

bind trit_gate_engine trit_gate_engine_chk chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .error(error), .stb(stb), .outVal(outVal), .rdData(rdData)
);

// File: tb/trit_gate_engine_tb_top.sv
`timescale 1ns/1ps
module trit_gate_engine_tb_top;
  localparam int CELLS = 8;
  localparam int AW    = $clog2(CELLS);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    opcode = '0;
  logic [AW-1:0] addrA = '0, addrB = '0, addrOut = '0, rdAddr = '0;
  logic [1:0]    rdData;
  logic          busy, done, error;

  int nChecks = 0;
  int nFails  = 0;
  int model [CELLS];

  always #2.5 clk = ~clk;

  trit_gate_engine #(.CELLS(CELLS)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .addrA(addrA), .addrB(addrB), .addrOut(addrOut),
    .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .done(done), .error(error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gateValue(input int op, input int a, input int b, input int old);
    case (op)
      0: return 0;
      1: return 2;
      2: return 1;
      3: return 2 - a;
      4: return (2 - a + b > 2) ? 2 : 2 - a + b;
      5: return (a + b > 2) ? 2 : a + b;
      default: return old;
    endcase
  endfunction

  function automatic int gateLatency(input int op);
    case (op)
      3: return 4;
      4: return 5;
      5: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string reqOf(input int op);
    case (op)
      0, 1, 2: return "R2";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R9";
    endcase
  endfunction

  // Compare every cell with the model (R7: only the output cell moves).
  task automatic scanCells(input string req);
    for (int i = 0; i < CELLS; i++) begin
      rdAddr = AW'(i);
      #0.2;
      check(int'(rdData) == model[i], req, int'(rdData), model[i]);
    end
    @(negedge clk);
  endtask

  task automatic runOp(input int op, input int a, input int b, input int o);
    int n;
    int expVal;
    int expLat;
    expVal = gateValue(op, model[a], model[b], model[o]);
    expLat = gateLatency(op);
    opcode  = 3'(op);
    addrA   = AW'(a);
    addrB   = AW'(b);
    addrOut = AW'(o);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin
      check(busy === 1'b1, "R10 busy during gate", int'(busy), 1);
      @(negedge clk);
      n++;
    end
    check(n == expLat, {reqOf(op), " latency"}, n, expLat);
    check(error === (op > 5), "R9 error flag", int'(error), int'(op > 5));
    check(busy === 1'b0, "R10 busy low at done", int'(busy), 0);
    model[o] = expVal;
    rdAddr = AW'(o);
    #0.2;
    check(int'(rdData) == expVal, {reqOf(op), " result"}, int'(rdData), expVal);
    @(negedge clk);
    check(done === 1'b0, "R10 done single pulse", int'(done), 0);
  endtask

  task automatic setCell(input int o, input int v);
    runOp((v == 0) ? 0 : (v == 1) ? 2 : 1, 0, 0, o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < CELLS; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1 reset flags",
          int'({busy, done, error}), 0);
    scanCells("R1 reset cells");

    // R2 constant gates ignore inputs
    setCell(1, 2);
    setCell(2, 1);
    runOp(1, 1, 2, 3);
    runOp(2, 2, 1, 3);
    runOp(0, 1, 1, 3);
    scanCells("R2 R7 const scan");

    // R4 inversion truth table, output pre-set nonzero (R3 clear)
    for (int a = 0; a < 3; a++) begin
      setCell(1, a);
      setCell(5, 2);
      runOp(3, 1, 0, 5);
      scanCells("R4 R7 scan");
    end

    // R5 implication and R6 strong disjunction truth tables
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        setCell(1, a);
        setCell(2, b);
        setCell(6, 1);
        runOp(4, 1, 2, 6);
        setCell(7, 2);
        runOp(5, 1, 2, 7);
        scanCells("R5 R6 R7 scan");
      end
    end

    // R7 aliasing: output equals input A
    setCell(1, 1);
    setCell(2, 2);
    runOp(4, 1, 2, 1);
    runOp(3, 1, 1, 1);
    runOp(5, 2, 2, 2);
    scanCells("R7 alias scan");

    // R9 undefined opcodes
    runOp(6, 1, 2, 2);
    runOp(7, 2, 1, 1);
    scanCells("R9 scan");

    // R8 start while busy is ignored
    setCell(1, 0);
    setCell(2, 1);
    setCell(4, 2);
    opcode = 3'(4); addrA = 1; addrB = 2; addrOut = 3;
    start = 1'b1;
    @(negedge clk);
    opcode = 3'(0); addrOut = 4;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(done === 1'b1, "R8 running gate done", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R8 no second gate",
          int'({done, busy}), 0);
    model[3] = 2;
    scanCells("R8 scan");

    // Random mix
    for (int k = 0; k < 300; k++) begin
      runOp(int'($urandom_range(7, 0)), int'($urandom_range(CELLS - 1, 0)),
            int'($urandom_range(CELLS - 1, 0)), int'($urandom_range(CELLS - 1, 0)));
      if (k % 10 == 0) scanCells("R7 random scan");
    end
    scanCells("R7 final scan");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule